// File: doc/BRIEF.md
# Calibration Readout Pattern Burst Generator

This block models the readout path a DDR3-style memory device offers for read-timing calibration. A three-bit readout control register, loaded through a write strobe, turns calibration readout on and selects the data function. While readout is on, each read command that carries a legal column address produces a burst of a fixed alternating pattern, 0 then 1 then 0 and so on. The burst starts a fixed number of clock cycles after the command. It is either eight beats long or chopped to four beats. A memory-controller model or a training engine sends reads and watches the data lanes and the valid flag to locate the data eye.

The burst length comes from a static burst-mode input. That input selects fixed eight-beat bursts, fixed four-beat bursts, or a choice made per command by column address bit 12. For a chopped burst, column address bit 2 picks the lower or the upper nibble of the burst order. A read with misaligned low address bits, or a read while a reserved function is selected, is flagged as an error and produces no data. When readout is off, reads are passed on as ordinary read indications and the pattern generator stays idle.

Top module: `cal_readout_top`

## Requirements
- R1: After reset the control register holds 0, so readout is off. A write with `mr3_we` high loads `mr3_din` and applies to commands issued in later cycles. Bit 2 is the enable and bits [1:0] are the function, where 00 is the calibration pattern and 01, 10 and 11 are reserved.
- R2: A read issued with the enable at 0 raises `norm_rd` for exactly one cycle, in the cycle after the command, and produces no `dq_valid` and no `rd_err`.
- R3: For an accepted read in cycle c, the first data beat appears in cycle c+READ_LAT, and `dq_valid` stays high for the whole burst.
- R4: An eight-beat burst shows `beat_pos` 0,1,2,3,4,5,6,7 on consecutive cycles. Each beat's data bit on every lane equals bit 0 of `beat_pos`, which gives the pattern 0,1,0,1,0,1,0,1 with the first beat carried in the LSB position of the order.
- R5: A four-beat burst with column address bit 2 at 0 shows `beat_pos` 0,1,2,3. With bit 2 at 1 it shows 4,5,6,7. In both cases the data is 0,1,0,1 and `dq_valid` is high for exactly 4 cycles.
- R6: `bl_mode` encoding: 00 gives fixed eight-beat bursts and 10 gives fixed four-beat bursts. 01 gives a per-command choice, where column address bit 12 at 1 means eight beats and at 0 means four beats. 11 behaves like 00.
- R7: Column address bit 2 has no effect on an eight-beat burst, whose order is always 0 to 7.
- R8: A read with readout on and column address bits [1:0] not equal to 00 raises `rd_err` for one cycle, in the cycle after the command, and produces no `dq_valid`.
- R9: A read with readout on and a function other than 00 raises `rd_err` in the cycle after the command and produces no data.
- R10: Column address bits [11:3] other than bit 12, bits above 12, and the bank address have no effect on any output.
- R11: While `dq_valid` is low, `dq_out` and `beat_pos` are 0. All data lanes always carry the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr3_we | input | 1 | Load strobe for the readout control register |
| mr3_din | input | 3 | Control value: bit 2 enable, bits [1:0] function |
| bl_mode | input | 2 | Burst-length mode (00 eight, 10 four, 01 per command, 11 eight) |
| cmd_rd | input | 1 | Read command, one cycle per command |
| cmd_addr | input | ADDR_W | Column address of the read |
| cmd_bank | input | BANK_W | Bank address, not used |
| dq_out | output | LANES | Pattern bit replicated on every lane |
| dq_valid | output | 1 | High during each data beat |
| beat_pos | output | 3 | Burst-order index of the current beat |
| rd_err | output | 1 | One-cycle flag for a rejected readout read |
| norm_rd | output | 1 | One-cycle flag for a read passed to the normal path |

## Verification
The bench builds the block with READ_LAT = 4 and two lanes. This keeps the latency pipe at two stages and each command window at about fifteen cycles, so a complete sweep can be run: all eight control register values, all four burst modes, all eight values of address bits [2:0], and both values of bit 12. The don't-care address and bank bits are scrambled on every command. Every cycle of every window is compared, which covers the first-beat cycle, the last beat, the cycle after the burst, and the error and pass-through cycles of each command.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int BEAT_W = 3;

  // burst-length mode codes
  typedef enum logic [1:0] {
    BLM_FIX8 = 2'b00,
    BLM_OTF  = 2'b01,
    BLM_FIX4 = 2'b10,
    BLM_RSV  = 2'b11
  } blm_e;

  // function code held in the low control bits
  localparam logic [1:0] FN_PATTERN = 2'b00;

  // one launch record travelling down the latency pipe
  typedef struct packed {
    logic vld;
    logic chop;   // four-beat burst
    logic upper;  // upper nibble of the order
  } launch_t;

  localparam launch_t LAUNCH_IDLE = '{vld: 1'b0, chop: 1'b0, upper: 1'b0};

  function automatic logic [BEAT_W-1:0] first_beat(input launch_t l);
    return {l.chop & l.upper, 2'b00};
  endfunction

  function automatic logic [BEAT_W-1:0] beats_left(input launch_t l);
    return l.chop ? 3'd3 : 3'd7;
  endfunction

endpackage

// File: rtl/cal_mr3_reg.sv
module cal_mr3_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [2:0] din,
  output logic       en,
  output logic [1:0] func
);

  logic [2:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 3'b000;
    end else if (we) begin
      q <= din;
    end
  end

  assign en   = q[2];
  assign func = q[1:0];

endmodule

// File: rtl/cal_cmd_decode.sv
module cal_cmd_decode
  import cal_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              en,
  input  logic [1:0]        func,
  input  logic [1:0]        bl_mode,
  output launch_t           launch,
  output logic              err_flag,
  output logic              norm_flag
);

  localparam int OTF_BIT = 12;
  localparam int NIB_BIT = 2;

  logic    misaligned;
  logic    bad_func;
  logic    reject;
  logic    chop;
  launch_t launch_d;
  logic    unused_bits;

  assign misaligned = (cmd_addr[1:0] != 2'b00);
  assign bad_func   = (func != FN_PATTERN);
  assign reject     = misaligned | bad_func;

  always_comb begin
    unique case (blm_e'(bl_mode))
      BLM_FIX4: chop = 1'b1;
      BLM_OTF:  chop = ~cmd_addr[OTF_BIT];
      default:  chop = 1'b0;
    endcase
  end

  always_comb begin
    launch_d       = LAUNCH_IDLE;
    launch_d.vld   = cmd_rd & en & ~reject;
    launch_d.chop  = chop;
    launch_d.upper = chop & cmd_addr[NIB_BIT];
  end

  // bits with no function, kept visible to avoid unused-input noise
  assign unused_bits = ^{cmd_bank, cmd_addr[ADDR_W-1:3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      launch    <= LAUNCH_IDLE;
      err_flag  <= 1'b0;
      norm_flag <= 1'b0;
    end else begin
      launch    <= launch_d;
      err_flag  <= cmd_rd & en & reject;
      norm_flag <= cmd_rd & ~en;
    end
  end

endmodule

// File: rtl/cal_lat_pipe.sv
module cal_lat_pipe
  import cal_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  launch_t din,
  output launch_t dout
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_stages
      launch_t stg [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_st
        always_ff @(posedge clk) begin
          if (rst) begin
            stg[i] <= LAUNCH_IDLE;
          end else if (i == 0) begin
            stg[i] <= din;
          end else begin
            stg[i] <= stg[(i == 0) ? 0 : i-1];
          end
        end
      end
      assign dout = stg[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/cal_burst_gen.sv
module cal_burst_gen
  import cal_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  launch_t           start,
  output logic [LANES-1:0]  dq_out,
  output logic              dq_valid,
  output logic [BEAT_W-1:0] beat_pos
);

  logic [BEAT_W-1:0] rem;
  logic [BEAT_W-1:0] pos_nx;
  logic [BEAT_W-1:0] first;

  assign first  = first_beat(start);
  assign pos_nx = beat_pos + 3'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_valid <= 1'b0;
      beat_pos <= '0;
      dq_out   <= '0;
      rem      <= '0;
    end else if (start.vld) begin
      dq_valid <= 1'b1;
      beat_pos <= first;
      dq_out   <= {LANES{first[0]}};
      rem      <= beats_left(start);
    end else if (rem != '0) begin
      dq_valid <= 1'b1;
      beat_pos <= pos_nx;
      dq_out   <= {LANES{pos_nx[0]}};
      rem      <= rem - 3'd1;
    end else begin
      dq_valid <= 1'b0;
      beat_pos <= '0;
      dq_out   <= '0;
    end
  end

endmodule

// File: rtl/cal_readout_top.sv
module cal_readout_top
  import cal_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int BANK_W   = 3,
  parameter int LANES    = 8,
  parameter int READ_LAT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mr3_we,
  input  logic [2:0]        mr3_din,
  input  logic [1:0]        bl_mode,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic [LANES-1:0]  dq_out,
  output logic              dq_valid,
  output logic [2:0]        beat_pos,
  output logic              rd_err,
  output logic              norm_rd
);

  // decode register and burst register each take one cycle of the latency
  localparam int PIPE_DEPTH = READ_LAT - 2;

  logic       mr3_en;
  logic [1:0] mr3_func;
  launch_t    dec_launch;
  launch_t    pipe_launch;

  cal_mr3_reg u_mr3 (
    .clk  (clk),
    .rst  (rst),
    .we   (mr3_we),
    .din  (mr3_din),
    .en   (mr3_en),
    .func (mr3_func)
  );

  cal_cmd_decode #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .cmd_rd    (cmd_rd),
    .cmd_addr  (cmd_addr),
    .cmd_bank  (cmd_bank),
    .en        (mr3_en),
    .func      (mr3_func),
    .bl_mode   (bl_mode),
    .launch    (dec_launch),
    .err_flag  (rd_err),
    .norm_flag (norm_rd)
  );

  cal_lat_pipe #(
    .DEPTH (PIPE_DEPTH)
  ) u_pipe (
    .clk  (clk),
    .rst  (rst),
    .din  (dec_launch),
    .dout (pipe_launch)
  );

  cal_burst_gen #(
    .LANES (LANES)
  ) u_burst (
    .clk      (clk),
    .rst      (rst),
    .start    (pipe_launch),
    .dq_out   (dq_out),
    .dq_valid (dq_valid),
    .beat_pos (beat_pos)
  );

endmodule

// File: rtl/cal_readout_chk.sv
module cal_readout_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] dq_out,
  input logic             dq_valid,
  input logic [2:0]       beat_pos,
  input logic             rd_err,
  input logic             norm_rd,
  input logic             mpr_en
);

  logic       prev_valid;
  logic [3:0] prev_pos;
  logic [3:0] run;
  logic       restart;

  assign restart = dq_valid && (!prev_valid || ({1'b0, beat_pos} != prev_pos + 4'd1));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid <= 1'b0;
      prev_pos   <= '0;
      run        <= '0;
    end else begin
      prev_valid <= dq_valid;
      prev_pos   <= {1'b0, beat_pos};
      if (!dq_valid)    run <= '0;
      else if (restart) run <= 4'd1;
      else              run <= run + 4'd1;
    end
  end

  // R11: idle lanes and index are quiet
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !dq_valid |-> (dq_out == '0 && beat_pos == 3'd0));

  // R11: all lanes identical
  p_lanes_same_r11: assert property (@(posedge clk) disable iff (rst)
    (dq_out == '0) || (dq_out == '1));

  // R5: every burst starts on a nibble boundary
  p_start_even_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_valid) |-> (beat_pos[1:0] == 2'b00));

  // R4: index steps by one inside a nibble
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (dq_valid && $past(dq_valid) && beat_pos[1:0] != 2'b00) |-> (beat_pos == $past(beat_pos) + 3'd1));

  // R4: no burst exceeds eight beats
  p_run_len_r4: assert property (@(posedge clk) disable iff (rst)
    run <= 4'd8);

  // R2: pass-through only when readout was off
  p_norm_gate_r2: assert property (@(posedge clk) disable iff (rst)
    norm_rd |-> !$past(mpr_en));

  // R8: error only when readout was on, never together with pass-through
  p_err_gate_r8: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> ($past(mpr_en) && !norm_rd));

endmodule

bind cal_readout_top cal_readout_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dq_out   (dq_out),
  .dq_valid (dq_valid),
  .beat_pos (beat_pos),
  .rd_err   (rd_err),
  .norm_rd  (norm_rd),
  .mpr_en   (mr3_en)
);

// File: tb/tb_cal_readout_top.sv
module tb_cal_readout_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 14;
  localparam int BANK_W     = 3;
  localparam int LANES      = 2;
  localparam int READ_LAT   = 4;
  localparam int WINDOW     = READ_LAT + 9;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mr3_we = 1'b0;
  logic [2:0]        mr3_din = '0;
  logic [1:0]        bl_mode = '0;
  logic              cmd_rd = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic [LANES-1:0]  dq_out;
  logic              dq_valid;
  logic [2:0]        beat_pos;
  logic              rd_err;
  logic              norm_rd;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_readout_top #(
    .ADDR_W   (ADDR_W),
    .BANK_W   (BANK_W),
    .LANES    (LANES),
    .READ_LAT (READ_LAT)
  ) dut (
    .clk      (clk),
    .rst      (rst),
    .mr3_we   (mr3_we),
    .mr3_din  (mr3_din),
    .bl_mode  (bl_mode),
    .cmd_rd   (cmd_rd),
    .cmd_addr (cmd_addr),
    .cmd_bank (cmd_bank),
    .dq_out   (dq_out),
    .dq_valid (dq_valid),
    .beat_pos (beat_pos),
    .rd_err   (rd_err),
    .norm_rd  (norm_rd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic write_mr3(input logic [2:0] v);
    @(negedge clk);
    mr3_we  = 1'b1;
    mr3_din = v;
    @(negedge clk);
    mr3_we  = 1'b0;
  endtask

  // issue one read and compare every cycle of its window
  task automatic run_cmd(input logic [2:0] mr3, input logic [1:0] blm,
                         input logic [2:0] alow, input logic a12);
    logic en, bad, chop, go;
    logic [2:0] first;
    int len;
    en    = mr3[2];
    bad   = (mr3[1:0] != 2'b00) || (alow[1:0] != 2'b00);
    go    = en && !bad;
    chop  = (blm == 2'b10) || (blm == 2'b01 && !a12);
    first = (chop && alow[2]) ? 3'd4 : 3'd0;
    len   = chop ? 4 : 8;
    step_lfsr();
    @(negedge clk);
    bl_mode  = blm;
    cmd_rd   = 1'b1;
    cmd_addr = {lfsr[ADDR_W-1:0]};
    cmd_addr[12]  = a12;
    cmd_addr[2:0] = alow;
    cmd_bank = lfsr[BANK_W+7:8];
    @(posedge clk);
    for (int k = 1; k <= WINDOW; k++) begin
      logic ev;
      logic [2:0] ep;
      @(negedge clk);
      if (k == 1) begin
        cmd_rd = 1'b0;
        check("R2 norm_rd", {31'd0, norm_rd}, {31'd0, !en});
        check(mr3[1:0] != 0 ? "R9 rd_err" : "R8 rd_err", {31'd0, rd_err}, {31'd0, en && bad});
      end else begin
        check("R2 R8 flags one cycle", {30'd0, norm_rd, rd_err}, 32'd0);
      end
      ev = go && (k >= READ_LAT) && (k < READ_LAT + len);
      ep = ev ? first + 3'(k - READ_LAT) : 3'd0;
      check(chop ? "R3 R5 R6 R7 R10 R11 burst" : "R3 R4 R6 R7 R10 R11 burst",
            {dq_out, dq_valid, beat_pos},
            {{LANES{ev & ep[0]}}, ev, ep});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 reset outputs", {dq_out, dq_valid, beat_pos, rd_err, norm_rd}, '0);
    // R1: readout off after reset, a legal read is passed through
    run_cmd(3'b000, 2'b00, 3'b000, 1'b0);
    for (int m = 0; m < 8; m++) begin
      write_mr3(3'(m));
      for (int b = 0; b < 4; b++) begin
        for (int a = 0; a < 8; a++) begin
          for (int h = 0; h < 2; h++) begin
            run_cmd(3'(m), 2'(b), 3'(a), 1'(h));
          end
        end
      end
    end
    // R1: write takes effect immediately for the next read
    write_mr3(3'b100);
    run_cmd(3'b100, 2'b10, 3'b100, 1'b0);
    write_mr3(3'b000);
    run_cmd(3'b000, 2'b00, 3'b000, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule